// File: doc/BRIEF.md
# UART Receive Interrupt Prioritizer

This block sits beside a UART receiver and decides which receive-side interrupt, if any, software sees first. It watches four receive error events, the receive FIFO fill level against a programmable trigger level, FIFO read and write activity, and two auto-baud events. From these it builds a 32-bit identification word and drives one interrupt line. It also contains the character time-out timer, which is clocked by quarter-character ticks from the baud logic.

Line-status errors have the top rank. Data-available and character time-out share the second rank; when both hold, data-available is reported. Auto-baud completion and auto-baud time-out are reported in their own bits (8 and 9), independent of the ranked 3-bit type field. Every pin is a plain control or status signal. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_rx_irq_prio`

## Requirements
- R1: While reset is held and in the first cycle after it, `irq_id` equals 32'h0000_0001, `irq` is 0 and `lsr_err` is 4'b0000.
- R2: When no ranked source is pending, `irq_id[0]` is 1 and `irq_id[3:1]` is 3'b000. When a ranked source is pending, `irq_id[0]` is 0.
- R3: A one-cycle pulse on any error input sets its sticky bit in `lsr_err` on the next clock. The bit order is overrun bit 0, parity bit 1, framing bit 2 and break bit 3. While any bit is set, `irq_id[3:1]` is 3'b011, whatever the other sources are doing.
- R4: A pulse on `lsr_rd` clears `lsr_err` on the next clock. An error pulse in the same cycle as the read stays set.
- R5: Data-available (`irq_id[3:1]` = 3'b010) holds combinationally while `fifo_level` is at or above the trigger level. The trigger level is 1, 4, 8 or 14 for `trig_sel` 00, 01, 10 or 11. It drops as soon as the level falls below the trigger.
- R6: With `fifo_level` nonzero and no FIFO read or write, the 16th `qchar_tick` pulse raises character time-out (`irq_id[3:1]` = 3'b110) from the next cycle on. Fifteen ticks are not enough.
- R7: A `fifo_rd` or `fifo_wr` pulse clears a pending time-out and restarts the tick count. A `fifo_level` of zero does the same.
- R8: When data-available and time-out are both pending and no line-status error is present, `irq_id[3:1]` reports 3'b010.
- R9: An `abd_done` pulse sets `irq_id[8]` only if `abd_done_en` is 1. `abd_done_clr` clears the bit. A set and a clear in the same cycle leave the bit set.
- R10: `abd_tmo` sets `irq_id[9]` under the same rules, using `abd_tmo_en` and `abd_tmo_clr`.
- R11: `irq` is 1 exactly when `irq_id[0]` is 0, or `irq_id[8]` is 1, or `irq_id[9]` is 1.
- R12: `irq_id[31:10]` and `irq_id[7:4]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_overrun | input | 1 | Overrun error event pulse |
| err_parity | input | 1 | Parity error event pulse |
| err_framing | input | 1 | Framing error event pulse |
| err_break | input | 1 | Break detected event pulse |
| lsr_rd | input | 1 | Line status read strobe |
| fifo_level | input | 5 | Receive FIFO fill count |
| trig_sel | input | 2 | Trigger level select |
| fifo_rd | input | 1 | Receive FIFO read strobe |
| fifo_wr | input | 1 | Receive FIFO write strobe |
| qchar_tick | input | 1 | Quarter-character time pulse |
| abd_done | input | 1 | Auto-baud finished event |
| abd_tmo | input | 1 | Auto-baud time-out event |
| abd_done_en | input | 1 | Enable for the finished flag |
| abd_tmo_en | input | 1 | Enable for the time-out flag |
| abd_done_clr | input | 1 | Clear for the finished flag |
| abd_tmo_clr | input | 1 | Clear for the time-out flag |
| irq_id | output | 32 | Interrupt identification word |
| lsr_err | output | 4 | Sticky receive error flags |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following: error flags stay set until a read, a read clears them, FIFO activity drops the time-out, the tick counter stays in bounds, disabled auto-baud events leave their flags clear, and data-available outranks time-out. Some behaviours can only be shown by the bench's scenarios. These are the exact tick on which time-out appears, the four trigger thresholds at their edges, the line-status error masking a live data-available, and read-versus-error and set-versus-clear collisions. The bench shows them by comparing the ports against its behavioural model and with directed checks.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'b000,
    SRC_DATA = 3'b010,
    SRC_LINE = 3'b011,
    SRC_IDLE = 3'b110
  } irq_src_e;

  localparam int ERR_N = 4;
  localparam int ABD_N = 2;
endpackage

// File: rtl/uart_irq_err_track.sv
module uart_irq_err_track #(
  parameter int N = uart_irq_pkg::ERR_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] err_ev,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= 1'b0;
      else if (err_ev[i]) flags[i] <= 1'b1;
      else if (rd_clr)    flags[i] <= 1'b0;
    end
  end

  // R3: flags are sticky unless a read occurs
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags)));
  // R4: a read with no new error empties the flags
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && err_ev == '0) |=> (flags == '0));
endmodule

// File: rtl/uart_irq_idle_timer.sv
module uart_irq_idle_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic activity,
  input  logic nonempty,
  input  logic qtick,
  output logic idle
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      idle <= 1'b0;
    end else if (activity || !nonempty) begin
      cnt  <= '0;
      idle <= 1'b0;
    end else if (qtick && !idle) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) idle <= 1'b1;
    end
  end

  // R7: FIFO activity always drops the time-out
  a_r7_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !idle);
  // R6: counter never runs past its limit
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TICKS));
endmodule

// File: rtl/uart_irq_abd_flags.sv
module uart_irq_abd_flags #(
  parameter int N = uart_irq_pkg::ABD_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag[i] <= 1'b0;
      else if (ev[i] && en[i])  flag[i] <= 1'b1;
      else if (clr[i])          flag[i] <= 1'b0;
    end

    // R9 / R10: a disabled event cannot raise a clear flag
    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ev[i] && en[i]) && !flag[i]) |=> !flag[i]);
  end
endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic            line_pend,
  input  logic            data_pend,
  input  logic            idle_pend,
  input  logic [1:0]      abd_flag,
  output logic [ID_W-1:0] id,
  output logic            irq
);
  irq_src_e src;
  logic     any_rank;

  always_comb begin
    if (line_pend)      src = SRC_LINE;
    else if (data_pend) src = SRC_DATA;
    else if (idle_pend) src = SRC_IDLE;
    else                src = SRC_NONE;
  end

  assign any_rank = line_pend | data_pend | idle_pend;

  always_comb begin
    id      = '0;
    id[0]   = ~any_rank;
    id[3:1] = src;
    id[9:8] = abd_flag;
  end

  assign irq = any_rank | (|abd_flag);
endmodule

// File: rtl/uart_rx_irq_prio.sv
module uart_rx_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TRIG0      = 1,
  parameter int TRIG1      = 4,
  parameter int TRIG2      = 8,
  parameter int TRIG3      = 14,
  parameter int IDLE_TICKS = 16,
  parameter int ID_W       = 32,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_overrun,
  input  logic            err_parity,
  input  logic            err_framing,
  input  logic            err_break,
  input  logic            lsr_rd,
  input  logic [LW-1:0]   fifo_level,
  input  logic [1:0]      trig_sel,
  input  logic            fifo_rd,
  input  logic            fifo_wr,
  input  logic            qchar_tick,
  input  logic            abd_done,
  input  logic            abd_tmo,
  input  logic            abd_done_en,
  input  logic            abd_tmo_en,
  input  logic            abd_done_clr,
  input  logic            abd_tmo_clr,
  output logic [ID_W-1:0] irq_id,
  output logic [3:0]      lsr_err,
  output logic            irq
);
  logic [LW-1:0] trig_lvl;
  logic          data_pend;
  logic          idle_pend;
  logic [1:0]    abd_flag;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = LW'(TRIG0);
      2'd1:    trig_lvl = LW'(TRIG1);
      2'd2:    trig_lvl = LW'(TRIG2);
      default: trig_lvl = LW'(TRIG3);
    endcase
  end

  assign data_pend = (fifo_level >= trig_lvl);

  uart_irq_err_track #(.N(ERR_N)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_ev ({err_break, err_framing, err_parity, err_overrun}),
    .rd_clr (lsr_rd),
    .flags  (lsr_err)
  );

  uart_irq_idle_timer #(.TICKS(IDLE_TICKS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (fifo_rd | fifo_wr),
    .nonempty (fifo_level != '0),
    .qtick    (qchar_tick),
    .idle     (idle_pend)
  );

  uart_irq_abd_flags #(.N(ABD_N)) u_abd (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    ({abd_tmo, abd_done}),
    .en    ({abd_tmo_en, abd_done_en}),
    .clr   ({abd_tmo_clr, abd_done_clr}),
    .flag  (abd_flag)
  );

  uart_irq_encode #(.ID_W(ID_W)) u_enc (
    .line_pend (|lsr_err),
    .data_pend (data_pend),
    .idle_pend (idle_pend),
    .abd_flag  (abd_flag),
    .id        (irq_id),
    .irq       (irq)
  );

  // R8: data-available outranks time-out when no error is held
  a_r8_data_over_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (data_pend && idle_pend && lsr_err == '0) |-> (irq_id[3:1] == 3'b010));
  // R3: any held error shows as line-status type
  a_r3_line_top: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_err != '0) |-> (irq_id[3:0] == 4'b0110));
endmodule

// File: tb/uart_rx_irq_prio_bench.sv
module uart_rx_irq_prio_bench;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe = 0, pe = 0, fe = 0, bi = 0, lsr_rd = 0;
  logic [4:0] fifo_level = '0;
  logic [1:0] trig_sel = '0;
  logic fifo_rd = 0, fifo_wr = 0, qtick = 0;
  logic abd_done = 0, abd_tmo = 0, done_en = 0, tmo_en = 0, done_clr = 0, tmo_clr = 0;
  logic [31:0] irq_id;
  logic [3:0] lsr_err;
  logic irq;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  int ref_err[4];
  int ref_cnt = 0;
  bit ref_idle = 0, ref_ab8 = 0, ref_ab9 = 0;

  always #(TCK/2) clk = ~clk;

  uart_rx_irq_prio u_uart_rx_irq_prio (
    .clk(clk), .rst_n(rst_n),
    .err_overrun(oe), .err_parity(pe), .err_framing(fe), .err_break(bi),
    .lsr_rd(lsr_rd), .fifo_level(fifo_level), .trig_sel(trig_sel),
    .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .qchar_tick(qtick),
    .abd_done(abd_done), .abd_tmo(abd_tmo),
    .abd_done_en(done_en), .abd_tmo_en(tmo_en),
    .abd_done_clr(done_clr), .abd_tmo_clr(tmo_clr),
    .irq_id(irq_id), .lsr_err(lsr_err), .irq(irq)
  );

  function automatic int trig_of(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  function automatic logic [31:0] ref_id();
    logic [31:0] w = 32'h0;
    bit line = (ref_err[0] + ref_err[1] + ref_err[2] + ref_err[3]) != 0;
    bit data = int'(fifo_level) >= trig_of(trig_sel);
    if (line)          w[3:0] = 4'b0110;
    else if (data)     w[3:0] = 4'b0100;
    else if (ref_idle) w[3:0] = 4'b1100;
    else               w[3:0] = 4'b0001;
    w[8] = ref_ab8;
    w[9] = ref_ab9;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // model update and compare on every cycle
  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      foreach (ref_err[i]) ref_err[i] = 0;
      ref_cnt = 0; ref_idle = 0; ref_ab8 = 0; ref_ab9 = 0;
    end else begin
      logic [3:0] ev;
      ev = {bi, fe, pe, oe};
      foreach (ref_err[i]) begin
        if (ev[i]) ref_err[i] = 1;
        else if (lsr_rd) ref_err[i] = 0;
      end
      if (fifo_rd || fifo_wr || fifo_level == 0) begin
        ref_cnt = 0; ref_idle = 0;
      end else if (qtick && !ref_idle) begin
        ref_cnt++;
        if (ref_cnt >= 16) ref_idle = 1;
      end
      if (abd_done && done_en) ref_ab8 = 1; else if (done_clr) ref_ab8 = 0;
      if (abd_tmo && tmo_en) ref_ab9 = 1; else if (tmo_clr) ref_ab9 = 0;
    end
    begin
      logic [31:0] e;
      e = ref_id();
      chk("model irq_id (R2 R3 R5 R6 R8 R9 R10 R12)", irq_id, e);
      chk("model lsr_err (R3 R4)", {28'h0, lsr_err},
          {28'h0, 1'(ref_err[3]), 1'(ref_err[2]), 1'(ref_err[1]), 1'(ref_err[0])});
      chk("model irq (R11)", {31'h0, irq},
          {31'h0, (e[0] == 1'b0) || e[8] || e[9]});
    end
  end

  task automatic cyc();
    @(negedge clk);
    #2;
  endtask

  task automatic clear_pulses();
    oe = 0; pe = 0; fe = 0; bi = 0; lsr_rd = 0;
    fifo_rd = 0; fifo_wr = 0; qtick = 0;
    abd_done = 0; abd_tmo = 0; done_clr = 0; tmo_clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      qtick = 1; cyc(); qtick = 0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements): got hang expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc();
    chk("R1 id in reset", irq_id, 32'h1);
    chk("R1 irq in reset", {31'h0, irq}, 32'h0);
    chk("R1 lsr_err in reset", {28'h0, lsr_err}, 32'h0);
    rst_n = 1; cyc();
    chk("R1 id after reset", irq_id, 32'h1);
    chk("R2 idle code", {28'h0, irq_id[3:0]}, 32'h1);

    // line status over data-available
    trig_sel = 2'b01; fifo_level = 5;
    cyc();
    chk("R5 data at level 5 trig 4", irq_id, 32'h4);
    oe = 1; cyc(); clear_pulses();
    chk("R3 overrun sets bit0", {28'h0, lsr_err}, 32'h1);
    chk("R3 line outranks data", irq_id, 32'h6);
    chk("R11 irq with line", {31'h0, irq}, 32'h1);
    fe = 1; cyc(); clear_pulses();
    chk("R3 framing sets bit2", {28'h0, lsr_err}, 32'h5);
    lsr_rd = 1; cyc(); clear_pulses();
    chk("R4 read clears", {28'h0, lsr_err}, 32'h0);
    chk("R4 data visible after read", irq_id, 32'h4);
    lsr_rd = 1; bi = 1; pe = 1; cyc(); clear_pulses();
    chk("R4 error during read kept", {28'h0, lsr_err}, 32'ha);
    lsr_rd = 1; cyc(); clear_pulses();
    chk("R4 second read clears", {28'h0, lsr_err}, 32'h0);

    // trigger thresholds
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      fifo_level = 5'(trig_of(2'(s)) - 1); cyc();
      chk("R5 below trigger", irq_id, 32'h1);
      fifo_level = 5'(trig_of(2'(s))); cyc();
      chk("R5 at trigger", irq_id, 32'h4);
    end

    // character time-out
    trig_sel = 2'b11; fifo_level = 3;
    fifo_wr = 1; cyc(); clear_pulses();
    ticks(15);
    chk("R6 fifteen ticks not enough", irq_id, 32'h1);
    ticks(1);
    chk("R6 sixteenth tick raises time-out", irq_id, 32'hc);
    chk("R11 irq with time-out", {31'h0, irq}, 32'h1);
    fifo_rd = 1; fifo_level = 2; cyc(); clear_pulses();
    chk("R7 read clears time-out", irq_id, 32'h1);
    ticks(16);
    chk("R6 time-out again", irq_id, 32'hc);
    fifo_level = 14; cyc();
    chk("R8 data over time-out", irq_id, 32'h4);
    fifo_level = 13; cyc();
    chk("R8 time-out back below trigger", irq_id, 32'hc);
    fifo_wr = 1; cyc(); clear_pulses();
    chk("R7 write clears time-out", irq_id, 32'h1);
    ticks(16);
    fifo_level = 0; cyc();
    chk("R7 empty FIFO clears time-out", irq_id, 32'h1);
    chk("R11 irq low when nothing pending", {31'h0, irq}, 32'h0);

    // auto-baud flags
    abd_done = 1; cyc(); clear_pulses();
    chk("R9 disabled done ignored", irq_id, 32'h1);
    done_en = 1; abd_done = 1; cyc(); clear_pulses();
    chk("R9 done sets bit8", irq_id, 32'h101);
    chk("R11 irq from bit8", {31'h0, irq}, 32'h1);
    done_clr = 1; cyc(); clear_pulses();
    chk("R9 clear drops bit8", irq_id, 32'h1);
    abd_done = 1; done_clr = 1; cyc(); clear_pulses();
    chk("R9 set wins over clear", irq_id, 32'h101);
    abd_tmo = 1; cyc(); clear_pulses();
    chk("R10 disabled time-out ignored", irq_id, 32'h101);
    tmo_en = 1; abd_tmo = 1; cyc(); clear_pulses();
    chk("R10 time-out sets bit9", irq_id, 32'h301);
    tmo_clr = 1; done_clr = 1; cyc(); clear_pulses();
    chk("R10 clears drop both", irq_id, 32'h1);
    chk("R12 reserved bits zero", {irq_id[31:10], irq_id[7:4]}, 26'h0);

    cyc(); cyc();
    summary();
    $finish;
  end
endmodule